// File: doc/BRIEF.md
# Page-Buffer Burst Read Packer

This block sits on the read path of a 16-byte page buffer. A single read request can return more than one buffer byte, packed into a word of 8, 16 or 32 bits, and can produce up to three such words one after another. It steps through consecutive buffer byte addresses, fetches one byte per cycle through a combinational buffer read port, and places each byte in the correct lane for the selected byte order. Each finished word is offered to the serial interface's output stream through a valid/ready handshake, with a last flag on the final word of the burst.

A write-only configuration word sets the packing. Bits 1:0 select the element width: 00 gives 8 bits, 01 gives 16 bits, and 10 or 11 give 32 bits. Bit 4 selects the byte order: 0 for little endian, 1 for big endian. Bits 11:8 give the number of words per read. A count of zero turns bursting off, so a read then returns a single plain byte. The settings are captured when a read starts, so a configuration write during a burst affects only later reads.

Top module: `page_burst_packer`

## Requirements
- R1: After reset, req_ready is 1, out_valid and out_last are 0, and the configuration count is 0.
- R2: With count field 0, a read returns exactly one word with out_last 1. Its bits 7:0 hold the byte at rd_addr, all higher bits are 0, and the width and order fields are ignored.
- R3: Width code 00, 01, 10 or 11 (cfg bits 1:0) packs 1, 2, 4 or 4 bytes per word. The bytes come from consecutive addresses starting at rd_addr, and unused upper bits are 0.
- R4: With cfg bit 4 at 0, the first byte of a word lands in bits 7:0. With cfg bit 4 at 1, it lands in the most significant byte of the element.
- R5: Count field values 1 to 3 (cfg bits 11:8) give that many words, and values above 3 give 3. Each word continues at the byte after the last byte of the previous word.
- R6: Byte addresses wrap modulo 16 within the page buffer.
- R7: An element width larger than BUS_W is reduced to BUS_W/8 bytes.
- R8: out_last is 1 only on the final word of a burst. After that word is accepted, the block returns to idle.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold steady.
- R10: A read request while req_ready is 0 is ignored and produces no extra words.
- R11: A configuration write during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (width 1:0, order 4, count 11:8) |
| rd_req | input | 1 | Start a burst read (taken when req_ready) |
| rd_addr | input | $clog2(PAGE_BYTES) | First buffer byte of the burst |
| req_ready | output | 1 | Block is idle and accepts a request |
| buf_addr | output | $clog2(PAGE_BYTES) | Page buffer read address |
| buf_data | input | 8 | Page buffer byte at buf_addr (same cycle) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | BUS_W | Packed output word |
| out_last | output | 1 | Final word of the burst |

## Verification
The bench sweeps every start address, width code, byte order and count from 0 to 5, and computes each expected word from a model of the buffer. A design that reversed the lane order would fail the big-endian cases. A design that restarted each word at rd_addr would repeat bytes, and one without modulo-16 addressing would read past byte 15 instead of returning to byte 0. On every burst the bench fires a second request and a configuration write mid-transfer. A design that restarted, or that read its configuration live, would emit extra or reshaped words. A second instance with a 16-bit bus shows whether 32-bit packing is reduced to two bytes or wrongly overflows the bus.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SEND} pbp_state_e;

  // bytes per element for a width code, limited to the bus width
  function automatic logic [7:0] elem_bytes(input logic [1:0] code, input logic [7:0] bus_bytes);
    logic [7:0] b;
    case (code)
      2'b00:   b = 8'd1;
      2'b01:   b = 8'd2;
      default: b = 8'd4;
    endcase
    if (b > bus_bytes) b = bus_bytes;
    return b;
  endfunction

  // words per read: 0 means a single plain byte read, above 3 clamps to 3
  function automatic logic [1:0] burst_words(input logic [3:0] field);
    if (field == 4'd0) return 2'd1;
    if (field > 4'd3) return 2'd3;
    return field[1:0];
  endfunction

  // lane that the k-th byte of an element occupies
  function automatic logic [7:0] byte_lane(input logic [7:0] k, input logic [7:0] bpw, input logic big);
    return big ? (bpw - 8'd1 - k) : k;
  endfunction

endpackage

// File: rtl/pbp_cfg_reg.sv
module pbp_cfg_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [1:0]  width_code,
  output logic        big_endian,
  output logic [3:0]  count_field
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wdata[15:12], wdata[7:5], wdata[3:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_code  <= 2'b00;
      big_endian  <= 1'b0;
      count_field <= 4'd0;
    end else if (we) begin
      width_code  <= wdata[1:0];
      big_endian  <= wdata[4];
      count_field <= wdata[11:8];
    end
  end
endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= start;
    else if (step)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/pbp_assembler.sv
module pbp_assembler #(
  parameter int BUS_W = 32,
  parameter int BCW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [BCW-1:0]   lane,
  input  logic [7:0]       din,
  output logic [BUS_W-1:0] word
);
  localparam int NLANES = BUS_W / 8;

  logic [7:0] lane_q [NLANES];

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                             lane_q[i] <= 8'd0;
      else if (clear)                         lane_q[i] <= 8'd0;
      else if (take && lane == BCW'(i))       lane_q[i] <= din;
    end
    assign word[i*8 +: 8] = lane_q[i];
  end
endmodule

// File: rtl/page_burst_packer.sv
module page_burst_packer
  import pbp_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [15:0]                   cfg_wdata,
  input  logic                          rd_req,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_addr,
  output logic                          req_ready,
  output logic [$clog2(PAGE_BYTES)-1:0] buf_addr,
  input  logic [7:0]                    buf_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BUS_W-1:0]              out_data,
  output logic                          out_last
);
  localparam int AW        = $clog2(PAGE_BYTES);
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int BCW       = $clog2(BUS_BYTES) + 1;

  logic [1:0] cfg_width;
  logic       cfg_big;
  logic [3:0] cfg_count;

  pbp_state_e     state_q;
  logic [BCW-1:0] byte_idx_q;
  logic [1:0]     word_idx_q;
  logic [BCW-1:0] snap_bpw_q;
  logic [1:0]     snap_words_q;
  logic           snap_big_q;

  // named internal events
  logic           burst_start;
  logic           byte_take;
  logic           word_fire;
  logic           fill_done;
  logic           final_word;
  logic [BCW-1:0] word_bytes;
  logic [BCW-1:0] lane;
  logic [BCW-1:0] start_bpw;

  pbp_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .wdata       (cfg_wdata),
    .width_code  (cfg_width),
    .big_endian  (cfg_big),
    .count_field (cfg_count)
  );

  assign burst_start = (state_q == ST_IDLE) && rd_req;
  assign byte_take   = (state_q == ST_FILL);
  assign word_fire   = (state_q == ST_SEND) && out_ready;
  assign fill_done   = (byte_idx_q == snap_bpw_q - 1'b1);
  assign final_word  = (word_idx_q == snap_words_q - 2'd1);
  assign word_bytes  = snap_bpw_q;
  assign start_bpw   = (cfg_count == 4'd0) ? BCW'(1)
                                           : BCW'(elem_bytes(cfg_width, 8'(BUS_BYTES)));
  assign lane        = BCW'(byte_lane(8'(byte_idx_q), 8'(snap_bpw_q), snap_big_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      byte_idx_q   <= '0;
      word_idx_q   <= 2'd0;
      snap_bpw_q   <= BCW'(1);
      snap_words_q <= 2'd1;
      snap_big_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (burst_start) begin
          snap_bpw_q   <= start_bpw;
          snap_words_q <= burst_words(cfg_count);
          snap_big_q   <= cfg_big && (cfg_count != 4'd0);
          byte_idx_q   <= '0;
          word_idx_q   <= 2'd0;
          state_q      <= ST_FILL;
        end
        ST_FILL: begin
          byte_idx_q <= byte_idx_q + 1'b1;
          if (fill_done) state_q <= ST_SEND;
        end
        ST_SEND: if (word_fire) begin
          if (final_word) state_q <= ST_IDLE;
          else begin
            state_q    <= ST_FILL;
            word_idx_q <= word_idx_q + 2'd1;
            byte_idx_q <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pbp_addr_gen #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (burst_start),
    .start (rd_addr),
    .step  (byte_take),
    .addr  (buf_addr)
  );

  pbp_assembler #(.BUS_W(BUS_W), .BCW(BCW)) u_asm (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (burst_start || word_fire),
    .take  (byte_take),
    .lane  (lane),
    .din   (buf_data),
    .word  (out_data)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_SEND);
  assign out_last  = out_valid && final_word;
endmodule

// File: rtl/pbp_checker.sv
module pbp_checker #(
  parameter int BUS_W      = 32,
  parameter int PAGE_BYTES = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               req_ready,
  input logic                               out_valid,
  input logic                               out_ready,
  input logic                               out_last,
  input logic [BUS_W-1:0]                   out_data,
  input logic [$clog2(PAGE_BYTES)-1:0]      buf_addr,
  input logic                               byte_take,
  input logic                               burst_start,
  input logic [$clog2(BUS_W/8):0]           word_bytes
);
  localparam int AW = $clog2(PAGE_BYTES);

  logic [2:0]    words_seen;
  logic          have_prev;
  logic [AW-1:0] prev_addr;
  logic [AW-1:0] next_addr;

  assign next_addr = prev_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_seen <= 3'd0;
      have_prev  <= 1'b0;
      prev_addr  <= '0;
    end else begin
      if (burst_start) begin
        words_seen <= 3'd0;
        have_prev  <= 1'b0;
      end else begin
        if (out_valid && out_ready) words_seen <= words_seen + 3'd1;
        if (byte_take) begin
          have_prev <= 1'b1;
          prev_addr <= buf_addr;
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> req_ready && !out_valid);

  a_r5_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> words_seen < 3'd3);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take && have_prev |-> buf_addr == next_addr);

  a_r2_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && word_bytes == 1 |-> (out_data >> 8) == '0);
endmodule

bind page_burst_packer pbp_checker #(.BUS_W(BUS_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_last    (out_last),
  .out_data    (out_data),
  .buf_addr    (buf_addr),
  .byte_take   (byte_take),
  .burst_start (burst_start),
  .word_bytes  (word_bytes)
);

// File: tb/page_burst_packer_tb.sv
`timescale 1ns/1ps
module page_burst_packer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        cfg_we0, cfg_we1;
  logic [15:0] cfg_wdata;
  logic        rd_req0, rd_req1;
  logic [3:0]  rd_addr;
  logic        out_ready;
  logic        req_ready0, req_ready1, out_valid0, out_valid1, out_last0, out_last1;
  logic [3:0]  buf_addr0, buf_addr1;
  logic [31:0] out_data0;
  logic [15:0] out_data1;
  logic [7:0]  mem [16];

  int checks = 0;
  int errors = 0;
  int rc = 0;
  bit done = 0;

  page_burst_packer #(.BUS_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we0), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req0), .rd_addr(rd_addr), .req_ready(req_ready0),
    .buf_addr(buf_addr0), .buf_data(mem[buf_addr0]),
    .out_valid(out_valid0), .out_ready(out_ready), .out_data(out_data0), .out_last(out_last0));

  page_burst_packer #(.BUS_W(16)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we1), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req1), .rd_addr(rd_addr), .req_ready(req_ready1),
    .buf_addr(buf_addr1), .buf_data(mem[buf_addr1]),
    .out_valid(out_valid1), .out_ready(out_ready), .out_data(out_data1), .out_last(out_last1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int a, input int w, input int bpw, input bit big);
    logic [31:0] r = '0;
    for (int k = 0; k < bpw; k++) begin
      logic [7:0] b = mem[(a + w * bpw + k) % 16];
      if (big) r = r | (32'(b) << (8 * (bpw - 1 - k)));
      else     r = r | (32'(b) << (8 * k));
    end
    return r;
  endfunction

  task automatic set_req(input int d, input logic v);
    if (d == 0) rd_req0 = v; else rd_req1 = v;
  endtask

  task automatic set_we(input int d, input logic v);
    if (d == 0) cfg_we0 = v; else cfg_we1 = v;
  endtask

  task automatic run_burst(input int d, input bit wr_cfg, input logic [15:0] cfg, input int a);
    int bus, bpw, nw, got, it, cnt, code;
    bit big, stalled;
    logic [31:0] act, held;
    logic vld, lst, rdy;
    string tag;
    bus  = (d == 0) ? 32 : 16;
    code = int'(cfg[1:0]);
    cnt  = int'(cfg[11:8]);
    big  = cfg[4];
    if (cnt == 0) begin bpw = 1; nw = 1; big = 0; end
    else begin
      bpw = (code == 0) ? 1 : (code == 1) ? 2 : 4;
      if (bpw > bus / 8) bpw = bus / 8;
      nw = (cnt > 3) ? 3 : cnt;
    end
    if (d == 1)                    tag = "R7";
    else if (cnt == 0)             tag = "R2";
    else if (a + nw * bpw > 16)    tag = "R6";
    else if (code == 3)            tag = "R3";
    else if (big)                  tag = "R4";
    else if (cnt > 3)              tag = "R5";
    else                           tag = "R3";
    if (wr_cfg) begin
      @(negedge clk); set_we(d, 1'b1); cfg_wdata = cfg;
      @(negedge clk); set_we(d, 1'b0);
    end else @(negedge clk);
    chk(((d == 0) ? req_ready0 : req_ready1) == 1'b1, "R1 idle before read",
        32'((d == 0) ? req_ready0 : req_ready1), 32'd1);
    set_req(d, 1'b1); rd_addr = 4'(a);
    got = 0; it = 0; stalled = 0; held = '0;
    while (got < nw && it < 200) begin
      @(negedge clk);
      if (it == 0) set_req(d, 1'b0);
      if (it == 1) begin
        // R10 R11: second request and config write during the burst
        set_req(d, 1'b1); rd_addr = 4'(a ^ 5);
        set_we(d, 1'b1); cfg_wdata = 16'h0312;
      end
      if (it == 2) begin set_req(d, 1'b0); set_we(d, 1'b0); end
      vld = (d == 0) ? out_valid0 : out_valid1;
      lst = (d == 0) ? out_last0 : out_last1;
      act = (d == 0) ? out_data0 : {16'd0, out_data1};
      rdy = (rc % 3) != 0; rc++;
      out_ready = rdy;
      if (vld) begin
        if (stalled) chk(act == held, "R9 data held during stall", act, held);
        if (rdy) begin
          chk(act == exp_word(a, got, bpw, big), tag, act, exp_word(a, got, bpw, big));
          chk(lst == (got == nw - 1), "R8 last flag", 32'(lst), 32'(got == nw - 1));
          got++; stalled = 0;
        end else begin
          stalled = 1; held = act;
        end
      end
      it++;
    end
    if (it >= 200) chk(1'b0, "R5 burst timed out", 32'(got), 32'(nw));
    @(negedge clk); set_req(d, 1'b0); set_we(d, 1'b0);
    repeat (3) @(negedge clk);
    vld = (d == 0) ? out_valid0 : out_valid1;
    rdy = (d == 0) ? req_ready0 : req_ready1;
    chk(!vld && rdy, "R10 R11 no extra words after burst", {30'd0, vld, rdy}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 29 + 7);
    rst_n = 0; cfg_we0 = 0; cfg_we1 = 0; cfg_wdata = '0;
    rd_req0 = 0; rd_req1 = 0; rd_addr = '0; out_ready = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready0 && !out_valid0 && !out_last0, "R1 reset state", {29'd0, req_ready0, out_valid0, out_last0}, 32'd4);
    chk(req_ready1 && !out_valid1 && !out_last1, "R1 reset state", {29'd0, req_ready1, out_valid1, out_last1}, 32'd4);
    run_burst(0, 1'b0, 16'h0000, 3);
    run_burst(1, 1'b0, 16'h0000, 9);
    for (int a = 0; a < 16; a++)
      for (int code = 0; code < 4; code++)
        for (int e = 0; e < 2; e++)
          for (int cnt = 0; cnt < 6; cnt++)
            run_burst(0, 1'b1, {4'd0, 4'(cnt), 3'd0, 1'(e), 2'd0, 2'(code)}, a);
    for (int code = 0; code < 4; code++)
      for (int e = 0; e < 2; e++)
        for (int ci = 0; ci < 3; ci++)
          for (int ai = 0; ai < 3; ai++)
            run_burst(1, 1'b1, {4'd0, 4'((ci == 0) ? 0 : ci + 1), 3'd0, 1'(e), 2'd0, 2'(code)},
                      (ai == 0) ? 0 : (ai == 1) ? 7 : 15);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule